// File: doc/BRIEF.md
# Masked Property Rule Table Evaluator

This block holds a programmable table of rules and, once per received frame, walks it from entry zero upward at one entry per clock. Each rule names one of sixteen 32-bit frame properties, a two-bit comparison code and a 32-bit operand. The properties arrive already extracted from the frame as one flat vector. Property 1 is a word of per-frame flag bits, for example VLAN present, jumbo, IPv4, IPv6, TCP, UDP and parse error. It is compared exactly like any other property.

A running 32-bit mask is set to all ones when a frame starts. A rule with a nonzero identifier ANDs its selected property with the mask and compares the result with its operand. A rule with identifier zero compares nothing. It copies its operand into the mask and gives a fixed pass or fail. The walk stops at the first passing rule and reports that rule's index. If the last rule fails, the block reports no match instead.

Software programs the table through an index register and two data write strobes, one for the control word and one for the operand. Both words of the indexed entry can be read back. While a frame is being evaluated, the block holds off host writes by raising busy.

Top module: `prop_rule_eval`

## Requirements
- R1: After reset, busy, done and match are low, the index register is 0, and every table entry reads back control 0 and operand 0.
- R2: A start accepted while idle raises busy in the following cycle with done low, and re-initialises the mask to 0xFFFF_FFFF for that frame whatever earlier frames loaded.
- R3: An entry whose identifier (control bits [3:0]) is 0 loads its operand into the mask. It passes when its code (control bits [5:4]) is 00 or 01 and fails when its code is 10 or 11.
- R4: An entry with a nonzero identifier passes when (property[id] & mask) relates to the operand by its code: 00 equal, 01 unsigned greater-or-equal, 10 not equal, 11 unsigned less-than.
- R5: The mask persists across later entries of the same frame until another identifier-zero entry reloads it. Masking never alters the property value seen by later entries.
- R6: Evaluation stops at the first passing entry i. Done pulses for one cycle with match high and match_idx = i, sampled i+2 cycles after the start cycle, and busy falls with it.
- R7: If no entry passes, done pulses with match low after all DEPTH entries, DEPTH+1 cycles after the start cycle.
- R8: Control bits [31:6] are reserved: they are dropped on write and always read back as zero.
- R9: While busy, writes to the index register, the control word and the operand are ignored, and read data stays constant.
- R10: A start strobe that arrives while busy is ignored. It neither restarts nor extends the walk, and it produces no second done.
- R11: The index register selects the entry that both host write strobes update and that both read ports show.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin evaluation of the current frame |
| props | input | 16*DW | Sixteen extracted properties, property k at bits [k*DW +: DW] |
| host_sel_we | input | 1 | Write the entry index register |
| host_sel_idx | input | IW | New entry index |
| host_ctl_we | input | 1 | Write the control word of the indexed entry |
| host_val_we | input | 1 | Write the operand of the indexed entry |
| host_wdata | input | DW | Host write data |
| host_ctl_rdata | output | DW | Control word of the indexed entry, reserved bits zero |
| host_val_rdata | output | DW | Operand of the indexed entry |
| busy | output | 1 | Evaluation in progress, host writes held off |
| done | output | 1 | One-cycle result strobe |
| match | output | 1 | With done: an entry passed |
| match_idx | output | IW | Index of the passing entry, valid with done and match |

## Verification
The checker assumes that the property vector stays stable from the start strobe until done. It also assumes that nothing outside the host port changes the table, so that read data can only move when the host writes. The bench holds each frame's properties fixed for the whole walk, and it changes them only between frames. It predicts every result from its own mirror of the table, and most sweeps run on an eight-entry table. The hold-off checks deliberately drive host writes and a second start while busy, and they confirm through the read ports and the done strobe that none of these took effect.

// File: rtl/prop_rule_pkg.sv
package prop_rule_pkg;

    localparam int PID_W = 4;
    localparam int NPROP = 1 << PID_W;
    localparam int OP_W  = 2;
    localparam int CTL_W = PID_W + OP_W;

    typedef enum logic [OP_W-1:0] {
        OP_EQ = 2'b00,
        OP_GE = 2'b01,
        OP_NE = 2'b10,
        OP_LT = 2'b11
    } rule_op_e;

    // control word: op at [5:4], property id at [3:0]
    typedef struct packed {
        rule_op_e           op;
        logic [PID_W-1:0]   pid;
    } rule_ctl_t;

endpackage

// File: rtl/prop_rule_cmp.sv
module prop_rule_cmp
    import prop_rule_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [NPROP*DW-1:0] props,
    input  rule_ctl_t           ctl,
    input  logic [DW-1:0]       operand,
    input  logic [DW-1:0]       mask,
    output logic                pass,
    output logic                load_mask
);

    logic [DW-1:0] sel_prop;
    logic [DW-1:0] masked;

    always_comb begin
        sel_prop = props[int'(ctl.pid)*DW +: DW];
        masked   = sel_prop & mask;   // R5: masked copy only
    end

    always_comb begin
        load_mask = (ctl.pid == '0);
        if (load_mask) begin
            // R3: fixed verdict from the high code bit
            pass = ~ctl.op[1];
        end else begin
            // R4: unsigned comparisons
            unique case (ctl.op)
                OP_EQ:   pass = (masked == operand);
                OP_GE:   pass = (masked >= operand);
                OP_NE:   pass = (masked != operand);
                OP_LT:   pass = (masked <  operand);
                default: pass = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/prop_rule_table.sv
module prop_rule_table
    import prop_rule_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int DW    = 32,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_ctl,
    input  logic          we_val,
    input  logic [IW-1:0] wr_idx,
    input  rule_ctl_t     wr_ctl,
    input  logic [DW-1:0] wr_val,
    input  logic [IW-1:0] ra_idx,
    output rule_ctl_t     ra_ctl,
    output logic [DW-1:0] ra_val,
    input  logic [IW-1:0] rb_idx,
    output rule_ctl_t     rb_ctl,
    output logic [DW-1:0] rb_val
);

    typedef struct packed {
        rule_ctl_t     ctl;
        logic [DW-1:0] val;
    } entry_t;

    entry_t ent_arr [DEPTH];

    for (genvar e = 0; e < DEPTH; e++) begin : g_ent
        entry_t ent_d, ent_q;

        always_comb begin
            ent_d = ent_q;
            if (wr_idx == IW'(e)) begin
                if (we_ctl) ent_d.ctl = wr_ctl;
                if (we_val) ent_d.val = wr_val;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) ent_q <= '0;   // R1
            else        ent_q <= ent_d;
        end

        assign ent_arr[e] = ent_q;
    end

    always_comb begin
        ra_ctl = ent_arr[ra_idx].ctl;
        ra_val = ent_arr[ra_idx].val;
        rb_ctl = ent_arr[rb_idx].ctl;
        rb_val = ent_arr[rb_idx].val;
    end

endmodule

// File: rtl/prop_rule_eval.sv
module prop_rule_eval
    import prop_rule_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int DW    = 32,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [NPROP*DW-1:0] props,
    input  logic                host_sel_we,
    input  logic [IW-1:0]       host_sel_idx,
    input  logic                host_ctl_we,
    input  logic                host_val_we,
    input  logic [DW-1:0]       host_wdata,
    output logic [DW-1:0]       host_ctl_rdata,
    output logic [DW-1:0]       host_val_rdata,
    output logic                busy,
    output logic                done,
    output logic                match,
    output logic [IW-1:0]       match_idx
);

    localparam logic [IW-1:0] LAST = IW'(DEPTH - 1);

    typedef struct packed {
        logic          busy;
        logic [IW-1:0] ptr;
        logic [DW-1:0] mask;
        logic          done;
        logic          hit;
        logic [IW-1:0] hit_idx;
        logic [IW-1:0] sel;
    } walk_t;

    walk_t st_d, st_q;

    rule_ctl_t     cur_ctl;
    logic [DW-1:0] cur_val;
    rule_ctl_t     host_ctl;
    logic          cur_pass;
    logic          cur_load;
    logic          wr_ok;

    // R9: host writes only while idle
    assign wr_ok = ~st_q.busy;

    // R11, R8: only the low control bits are stored
    prop_rule_table #(.DEPTH(DEPTH), .DW(DW)) u_table (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_ctl (host_ctl_we & wr_ok),
        .we_val (host_val_we & wr_ok),
        .wr_idx (st_q.sel),
        .wr_ctl (rule_ctl_t'(host_wdata[CTL_W-1:0])),
        .wr_val (host_wdata),
        .ra_idx (st_q.sel),
        .ra_ctl (host_ctl),
        .ra_val (host_val_rdata),
        .rb_idx (st_q.ptr),
        .rb_ctl (cur_ctl),
        .rb_val (cur_val)
    );

    prop_rule_cmp #(.DW(DW)) u_cmp (
        .props     (props),
        .ctl       (cur_ctl),
        .operand   (cur_val),
        .mask      (st_q.mask),
        .pass      (cur_pass),
        .load_mask (cur_load)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        st_d.hit  = 1'b0;

        if (host_sel_we && wr_ok) st_d.sel = host_sel_idx;

        if (!st_q.busy) begin
            if (start) begin
                // R2: fresh mask for each frame
                st_d.busy = 1'b1;
                st_d.ptr  = '0;
                st_d.mask = '1;
            end
        end else begin
            // R10: start ignored here
            if (cur_load) st_d.mask = cur_val;   // R3, R5
            if (cur_pass) begin
                // R6
                st_d.busy    = 1'b0;
                st_d.done    = 1'b1;
                st_d.hit     = 1'b1;
                st_d.hit_idx = st_q.ptr;
            end else if (st_q.ptr == LAST) begin
                // R7
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end else begin
                st_d.ptr = st_q.ptr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.mask <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign host_ctl_rdata = {{(DW-CTL_W){1'b0}}, host_ctl};
    assign busy           = st_q.busy;
    assign done           = st_q.done;
    assign match          = st_q.hit;
    assign match_idx      = st_q.hit_idx;

endmodule

// File: rtl/prop_rule_eval_chk.sv
module prop_rule_eval_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic          match,
    input logic [DW-1:0] host_ctl_rdata,
    input logic [DW-1:0] host_val_rdata
);

    // R2
    start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && !done));

    // R6
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R6
    done_after_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy));

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    match_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match |-> done);

    // R9
    hold_table_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(host_ctl_rdata) && $stable(host_val_rdata)));

endmodule

bind prop_rule_eval prop_rule_eval_chk #(.DW(DW)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .start          (start),
    .busy           (busy),
    .done           (done),
    .match          (match),
    .host_ctl_rdata (host_ctl_rdata),
    .host_val_rdata (host_val_rdata)
);

// File: tb/prop_rule_eval_bench.sv
`timescale 1ns/1ps
module prop_rule_eval_bench;

    localparam int DEPTH = 8;
    localparam int DW    = 32;
    localparam int IW    = $clog2(DEPTH);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [16*DW-1:0]  props;
    logic              host_sel_we = 1'b0;
    logic [IW-1:0]     host_sel_idx = '0;
    logic              host_ctl_we = 1'b0;
    logic              host_val_we = 1'b0;
    logic [DW-1:0]     host_wdata = '0;
    logic [DW-1:0]     host_ctl_rdata;
    logic [DW-1:0]     host_val_rdata;
    logic              busy, done, match;
    logic [IW-1:0]     match_idx;

    logic [31:0] prop_b [16];
    logic [5:0]  m_ctl [DEPTH];
    logic [31:0] m_val [DEPTH];
    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    always_comb begin
        for (int k = 0; k < 16; k++) props[k*DW +: DW] = prop_b[k];
    end

    prop_rule_eval #(.DEPTH(DEPTH), .DW(DW)) u_prop_rule_eval (
        .clk(clk), .rst_n(rst_n), .start(start), .props(props),
        .host_sel_we(host_sel_we), .host_sel_idx(host_sel_idx),
        .host_ctl_we(host_ctl_we), .host_val_we(host_val_we),
        .host_wdata(host_wdata), .host_ctl_rdata(host_ctl_rdata),
        .host_val_rdata(host_val_rdata), .busy(busy), .done(done),
        .match(match), .match_idx(match_idx)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [5:0] mk(input int pid, input int code);
        return {code[1:0], pid[3:0]};
    endfunction

    task automatic set_sel(input int i);
        @(negedge clk); host_sel_we = 1'b1; host_sel_idx = IW'(i);
        @(negedge clk); host_sel_we = 1'b0;
    endtask

    task automatic wr_entry(input int i, input logic [31:0] ctlw, input logic [31:0] val);
        set_sel(i);
        host_ctl_we = 1'b1; host_wdata = ctlw;
        @(negedge clk); host_ctl_we = 1'b0; host_val_we = 1'b1; host_wdata = val;
        @(negedge clk); host_val_we = 1'b0;
        m_ctl[i] = ctlw[5:0];
        m_val[i] = val;
    endtask

    // bench model of the walk
    task automatic model(output bit hit, output int idx);
        logic [31:0] mk_r, p;
        bit h;
        mk_r = 32'hFFFF_FFFF; hit = 0; idx = 0;
        for (int i = 0; i < DEPTH; i++) begin
            if (m_ctl[i][3:0] == 4'd0) begin
                mk_r = m_val[i];
                h = (m_ctl[i][5] == 1'b0);
            end else begin
                p = prop_b[m_ctl[i][3:0]] & mk_r;
                case (m_ctl[i][5:4])
                    2'd0: h = (p == m_val[i]);
                    2'd1: h = (p >= m_val[i]);
                    2'd2: h = (p != m_val[i]);
                    default: h = (p < m_val[i]);
                endcase
            end
            if (h) begin hit = 1; idx = i; return; end
        end
    endtask

    task automatic run(output bit got_done, output bit m, output int idx, output int cyc);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        cyc = 1; got_done = 0; m = 0; idx = 0;
        while (!done && cyc < 100) begin @(negedge clk); cyc++; end
        if (done) begin got_done = 1; m = match; idx = int'(match_idx); end
    endtask

    task automatic frame(input string req);
        bit eh, gd, gm; int ei, gi, gc;
        model(eh, ei);
        run(gd, gm, gi, gc);
        chk(gd, req, 32'(gd), 32'd1);
        chk(gm == eh, req, 32'(gm), 32'(eh));
        if (eh) begin
            chk(gi == ei, {req, " R6 idx"}, gi, ei);
            chk(gc == ei + 2, {req, " R6 latency"}, gc, ei + 2);
        end else begin
            chk(gc == DEPTH + 1, {req, " R7 latency"}, gc, DEPTH + 1);
        end
    endtask

    task automatic fill_fail();
        for (int i = 0; i < DEPTH; i++) wr_entry(i, 32'(mk(0, 2)), 32'hFFFF_FFFF);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int k = 0; k < 16; k++) prop_b[k] = (k % 2) ? 32'h8000_0010 + 32'(k * 7) : 32'(k * 13 + 5);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(!busy && !done && !match, "R1 flags", {busy, done, match}, 0);
        for (int i = 0; i < DEPTH; i++) begin
            set_sel(i);
            chk(host_ctl_rdata == 0 && host_val_rdata == 0, "R1 table", host_ctl_rdata ^ host_val_rdata, 0);
        end

        // R8 reserved bits, R11 index selects entry
        wr_entry(3, 32'hFFFF_FFC0 | 32'(mk(5, 3)), 32'hDEAD_0003);
        wr_entry(4, 32'(mk(6, 1)), 32'h1234_0004);
        set_sel(3);
        chk(host_ctl_rdata == 32'h35, "R8 readback", host_ctl_rdata, 32'h35);
        chk(host_val_rdata == 32'hDEAD_0003, "R11 entry3", host_val_rdata, 32'hDEAD_0003);
        set_sel(4);
        chk(host_ctl_rdata == 32'h16, "R11 ctl entry4", host_ctl_rdata, 32'h16);
        chk(host_val_rdata == 32'h1234_0004, "R11 val entry4", host_val_rdata, 32'h1234_0004);

        // R7 all entries fail
        fill_fail();
        frame("R7 nomatch");

        // R4 sweep of ids, codes and relations
        for (int pid = 1; pid < 16; pid++)
            for (int code = 0; code < 4; code++)
                for (int rel = -1; rel <= 1; rel++) begin
                    wr_entry(0, 32'(mk(pid, code)), prop_b[pid] + 32'(rel));
                    frame("R4 compare");
                end

        // R3 id zero verdicts and mask load
        fill_fail();
        for (int code = 0; code < 4; code++) begin
            wr_entry(0, 32'(mk(0, code)), 32'h0000_FFFF);
            wr_entry(1, 32'(mk(3, 0)), prop_b[3] & 32'h0000_FFFF);
            frame("R3 idzero");
        end

        // R5 masking leaves the property intact for later entries
        fill_fail();
        wr_entry(0, 32'(mk(0, 2)), 32'h0000_00F0);
        wr_entry(1, 32'(mk(7, 0)), prop_b[7]);
        wr_entry(2, 32'(mk(0, 3)), 32'hFFFF_FFFF);
        wr_entry(3, 32'(mk(7, 0)), prop_b[7]);
        frame("R5 persist");

        // R2 mask re-initialised per frame
        fill_fail();
        wr_entry(0, 32'(mk(2, 0)), 32'h0000_0ABC);
        wr_entry(1, 32'(mk(0, 2)), 32'h0);
        prop_b[2] = 32'h0000_0111;
        frame("R2 frame1");
        prop_b[2] = 32'h0000_0ABC;
        frame("R2 frame2");

        // R9, R10 writes and start while busy
        fill_fail();
        set_sel(2);
        begin
            int dones, cyc;
            @(negedge clk); start = 1'b1;
            @(negedge clk); start = 1'b0;
            host_sel_we = 1'b1; host_sel_idx = IW'(5);
            host_ctl_we = 1'b1; host_wdata = 32'(mk(9, 1));
            @(negedge clk);
            host_sel_we = 1'b0; host_ctl_we = 1'b0;
            host_val_we = 1'b1; host_wdata = 32'h5555_AAAA; start = 1'b1;
            @(negedge clk);
            host_val_we = 1'b0; start = 1'b0;
            cyc = 3; dones = 0;
            while (!done && cyc < 100) begin @(negedge clk); cyc++; end
            chk(cyc == DEPTH + 1, "R10 no restart", cyc, DEPTH + 1);
            for (int w = 0; w < DEPTH + 4; w++) begin
                @(negedge clk);
                if (done) dones++;
            end
            chk(dones == 0 && !busy, "R10 no second done", dones, 0);
            chk(host_ctl_rdata == 32'(m_ctl[2]), "R9 index held", host_ctl_rdata, 32'(m_ctl[2]));
            chk(host_val_rdata == m_val[2], "R9 operand held", host_val_rdata, m_val[2]);
            set_sel(5);
            chk(host_ctl_rdata == 32'(m_ctl[5]) && host_val_rdata == m_val[5], "R9 entry5 held",
                host_ctl_rdata, 32'(m_ctl[5]));
        end

        // random tables: R3 R4 R5 R6 R7 together
        for (int t = 0; t < 250; t++) begin
            for (int k = 0; k < 16; k++) prop_b[k] = $urandom;
            for (int i = 0; i < DEPTH; i++) begin
                int pid;
                logic [31:0] v;
                pid = ($urandom % 4 == 0) ? 0 : 1 + ($urandom % 15);
                v = ($urandom % 2) ? prop_b[pid] & ($urandom | $urandom) : $urandom;
                wr_entry(i, 32'(mk(pid, $urandom % 4)), v);
            end
            frame("R4 R5 random");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule